// File: doc/BRIEF.md
# Control-IN Single-Packet Transmit Buffer

This block holds one outgoing data packet for the IN direction of a device-side control endpoint. Firmware loads the packet one byte at a time through an 8-bit write-only port and then pulses a commit trigger. Until that trigger arrives, the bytes are never offered for transmission, and any IN token from the host is answered with NAK. Once the packet is committed, the serial interface engine pulls the bytes out in the order they were written.

The packet stays committed until the host acknowledges it. The host ACK empties the buffer and sets a transmit-complete interrupt flag. That flag is sticky until firmware clears it with a write of 1. If the host does not acknowledge, for example after a timeout or a corrupted handshake, the engine signals a retry. The read position then rewinds, so the same bytes can be sent again.

Firmware writes made while a packet is committed are discarded. Writes past capacity are dropped and set an overflow status bit. A dedicated clear input resets the buffer at any time. Committing with no bytes written produces a zero-length packet.

Top module: `ctl_in_txbuf`

## Requirements
- R1: After reset the buffer is not armed, holds 0 bytes, offers no data (`sie_avail_o`=0), and both `ovf_o` and `tx_done_o` are 0.
- R2: While not armed, each `fw_wr_i` cycle stores `fw_data_i` at the next position and increments `cnt_o` by one, up to DEPTH (8 by default).
- R3: A write while not armed and with `cnt_o`=DEPTH is dropped and sets `ovf_o`. `ovf_o` stays 1 until `fw_clr_i`.
- R4: Before commit, an IN token (`sie_in_tok_i`=1) gives `sie_nak_o`=1 in the same cycle. A `fw_arm_i` pulse sets `armed_o` on the next edge, and after that a token gives `sie_nak_o`=0.
- R5: While armed, `sie_data_o` presents the bytes in write order. Each `sie_rd_i` cycle advances to the next byte. `sie_avail_o` is 1 exactly while unread bytes of the committed packet remain.
- R6: Firmware writes while armed change neither `cnt_o` nor the stored bytes.
- R7: `sie_ack_i` while armed sets `tx_done_o`, clears `armed_o` and resets `cnt_o` to 0 at the next edge. `sie_ack_i` while not armed leaves `tx_done_o` unchanged.
- R8: `sie_retry_i` while armed rewinds the read position to the first byte and keeps the packet armed.
- R9: `tx_done_o` is sticky and is cleared only by `fw_flag_clr_i`. When ACK and flag-clear arrive in the same cycle, the flag is set.
- R10: `fw_clr_i` clears `armed_o`, `cnt_o`, the read position and `ovf_o` at the next edge, overrides every other input, and leaves `tx_done_o` unchanged.
- R11: `fw_arm_i` with 0 bytes written arms a zero-length packet. Tokens are no longer NAKed, `sie_avail_o` stays 0, and an ACK sets `tx_done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fw_wr_i | input | 1 | Firmware byte write strobe |
| fw_data_i | input | 8 | Firmware write data |
| fw_arm_i | input | 1 | Commit trigger pulse |
| fw_clr_i | input | 1 | Buffer clear |
| fw_flag_clr_i | input | 1 | Write-1-to-clear for the completion flag |
| sie_in_tok_i | input | 1 | IN token addressed to this endpoint |
| sie_rd_i | input | 1 | Engine takes the current byte |
| sie_ack_i | input | 1 | Host ACK received after transmission |
| sie_retry_i | input | 1 | No ACK received; resend the packet |
| sie_nak_o | output | 1 | Answer the current token with NAK |
| sie_avail_o | output | 1 | An unread committed byte is on sie_data_o |
| sie_data_o | output | 8 | Current byte to transmit |
| armed_o | output | 1 | Packet committed |
| cnt_o | output | 4 | Bytes held in the buffer |
| ovf_o | output | 1 | Sticky overflow status |
| tx_done_o | output | 1 | Sticky transmit-complete flag |

## Verification
The bench builds the block with its defaults: DEPTH=8 and 8-bit data. With a capacity of one full packet, an overflow is reached by writing only nine or ten bytes. The same build covers a full 8-byte packet, short packets, a zero-length packet, and the rewind of a partly read packet. The vector table sends packets of different lengths and contents through the whole fill, commit, read and ACK cycle. Directed cases then cover collisions: a write while armed, ACK and flag-clear in the same cycle, ACK with nothing armed, and clear during a committed packet.

// File: rtl/ctl_in_txbuf_pkg.sv
package ctl_in_txbuf_pkg;
  typedef enum logic {BUF_FILL = 1'b0, BUF_ARMED = 1'b1} buf_state_e;

  function automatic int cnt_width(input int depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/txbuf_store.sv
module txbuf_store #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  parameter int AW    = 3,
  parameter int CW    = 4
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [CW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i) begin
      if (we_i && waddr_i == AW'(g)) mem[g] <= wdata_i;
    end
  end

  // read position may sit one past the last entry
  assign rdata_o = (raddr_i < CW'(DEPTH)) ? mem[raddr_i[AW-1:0]] : '0;
endmodule

// File: rtl/txbuf_ctrl.sv
module txbuf_ctrl
  import ctl_in_txbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  parameter int CW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          arm_i,
  input  logic          clr_i,
  input  logic          rd_i,
  input  logic          ack_i,
  input  logic          retry_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [CW-1:0] rd_ptr_o,
  output logic [CW-1:0] cnt_o,
  output logic          armed_o,
  output logic          ovf_o,
  output logic          done_o
);
  buf_state_e    state_q;
  logic [CW-1:0] cnt_q, rd_q;
  logic          ovf_q;
  logic          room;

  assign room    = cnt_q < CW'(DEPTH);
  assign we_o    = wr_i && !clr_i && state_q == BUF_FILL && room;
  assign waddr_o = cnt_q[AW-1:0];
  assign done_o  = ack_i && !clr_i && state_q == BUF_ARMED;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BUF_FILL;
      cnt_q   <= '0;
      rd_q    <= '0;
      ovf_q   <= 1'b0;
    end else if (clr_i) begin
      state_q <= BUF_FILL;
      cnt_q   <= '0;
      rd_q    <= '0;
      ovf_q   <= 1'b0;
    end else begin
      unique case (state_q)
        BUF_FILL: begin
          if (wr_i) begin
            if (room) cnt_q <= cnt_q + 1'b1;
            else      ovf_q <= 1'b1;
          end
          if (arm_i) begin
            state_q <= BUF_ARMED;
            rd_q    <= '0;
          end
        end
        BUF_ARMED: begin
          if (ack_i) begin
            state_q <= BUF_FILL;
            cnt_q   <= '0;
            rd_q    <= '0;
          end else if (retry_i) begin
            rd_q <= '0;
          end else if (rd_i && rd_q < cnt_q) begin
            rd_q <= rd_q + 1'b1;
          end
        end
        default: state_q <= BUF_FILL;
      endcase
    end
  end

  assign rd_ptr_o = rd_q;
  assign cnt_o    = cnt_q;
  assign armed_o  = state_q == BUF_ARMED;
  assign ovf_o    = ovf_q;

  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  // R6
  armed_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BUF_ARMED && !clr_i && !ack_i) |=> $stable(cnt_q));
  // R3
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !clr_i) |=> ovf_q);
  // R8
  retry_rewind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BUF_ARMED && retry_i && !ack_i && !clr_i) |=> (rd_q == '0 && state_q == BUF_ARMED));
  // R10
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && rd_q == '0 && state_q == BUF_FILL && !ovf_q));
  // R5
  rd_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_q <= cnt_q);
endmodule

// File: rtl/txbuf_flag.sv
module txbuf_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic w1c_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (w1c_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R7
  flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(set_i));
  // R9
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !w1c_i) |=> flag_q);
endmodule

// File: rtl/ctl_in_txbuf.sv
module ctl_in_txbuf
  import ctl_in_txbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = cnt_width(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fw_wr_i,
  input  logic [DW-1:0] fw_data_i,
  input  logic          fw_arm_i,
  input  logic          fw_clr_i,
  input  logic          fw_flag_clr_i,
  input  logic          sie_in_tok_i,
  input  logic          sie_rd_i,
  input  logic          sie_ack_i,
  input  logic          sie_retry_i,
  output logic          sie_nak_o,
  output logic          sie_avail_o,
  output logic [DW-1:0] sie_data_o,
  output logic          armed_o,
  output logic [CW-1:0] cnt_o,
  output logic          ovf_o,
  output logic          tx_done_o
);
  logic          we;
  logic [AW-1:0] waddr;
  logic [CW-1:0] rd_ptr, cnt;
  logic          armed, done;

  txbuf_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (fw_wr_i),
    .arm_i    (fw_arm_i),
    .clr_i    (fw_clr_i),
    .rd_i     (sie_rd_i),
    .ack_i    (sie_ack_i),
    .retry_i  (sie_retry_i),
    .we_o     (we),
    .waddr_o  (waddr),
    .rd_ptr_o (rd_ptr),
    .cnt_o    (cnt),
    .armed_o  (armed),
    .ovf_o    (ovf_o),
    .done_o   (done)
  );

  txbuf_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .CW(CW)) u_store (
    .clk_i   (clk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (fw_data_i),
    .raddr_i (rd_ptr),
    .rdata_o (sie_data_o)
  );

  txbuf_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (done),
    .w1c_i  (fw_flag_clr_i),
    .flag_o (tx_done_o)
  );

  assign sie_nak_o   = sie_in_tok_i && !armed;
  assign sie_avail_o = armed && rd_ptr < cnt;
  assign armed_o     = armed;
  assign cnt_o       = cnt;

  // R4
  nak_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sie_in_tok_i && !armed_o) |-> sie_nak_o);
  // R11
  zlp_no_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && cnt_o == '0) |-> !sie_avail_o);
endmodule

// File: tb/ctl_in_txbuf_bench.sv
module ctl_in_txbuf_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fw_wr_i = 0, fw_arm_i = 0, fw_clr_i = 0, fw_flag_clr_i = 0;
  logic [7:0] fw_data_i = '0;
  logic       sie_in_tok_i = 0, sie_rd_i = 0, sie_ack_i = 0, sie_retry_i = 0;
  logic       sie_nak_o, sie_avail_o, armed_o, ovf_o, tx_done_o;
  logic [7:0] sie_data_o;
  logic [3:0] cnt_o;

  int checks = 0;
  int failures = 0;

  always #4 clk_i = ~clk_i;

  ctl_in_txbuf u_ctl_in_txbuf (.*);

  // {length, seed}
  localparam logic [15:0] VEC [4] = '{16'h0811, 16'h03A0, 16'h015C, 16'h06E7};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #2;
  endtask

  task automatic wr_byte(input logic [7:0] b);
    fw_wr_i = 1; fw_data_i = b; tick(); fw_wr_i = 0;
  endtask

  task automatic arm();
    fw_arm_i = 1; tick(); fw_arm_i = 0;
  endtask

  task automatic ack();
    sie_ack_i = 1; tick(); sie_ack_i = 0;
  endtask

  task automatic flag_clr();
    fw_flag_clr_i = 1; tick(); fw_flag_clr_i = 0;
  endtask

  task automatic read_chk(input string req, input logic [7:0] exp);
    check(req, sie_avail_o, 1);
    check(req, sie_data_o, exp);
    sie_rd_i = 1; tick(); sie_rd_i = 0;
  endtask

  task automatic tok_chk(input string req, input logic exp_nak);
    sie_in_tok_i = 1; #1;
    check(req, sie_nak_o, exp_nak);
    sie_in_tok_i = 0;
  endtask

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    return seed + 8'(i * 19);
  endfunction

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1;
    #1;
    // R1 reset state
    check("R1 armed", armed_o, 0);
    check("R1 cnt", cnt_o, 0);
    check("R1 avail", sie_avail_o, 0);
    check("R1 ovf", ovf_o, 0);
    check("R1 done", tx_done_o, 0);

    for (int v = 0; v < 4; v++) begin
      int len;
      logic [7:0] seed;
      len = int'(VEC[v][15:8]);
      seed = VEC[v][7:0];
      for (int i = 0; i < len; i++) wr_byte(pat(seed, i));
      check("R2 cnt", cnt_o, len);
      tok_chk("R4 nak before arm", 1);
      check("R4 no data before arm", sie_avail_o, 0);
      arm();
      check("R4 armed", armed_o, 1);
      tok_chk("R4 no nak when armed", 0);
      for (int i = 0; i < len; i++) read_chk("R5 data", pat(seed, i));
      check("R5 avail drops", sie_avail_o, 0);
      ack();
      check("R7 done", tx_done_o, 1);
      check("R7 disarm", armed_o, 0);
      check("R7 cnt", cnt_o, 0);
      flag_clr();
      check("R9 w1c", tx_done_o, 0);
    end

    // R3 overflow
    for (int i = 0; i < 10; i++) wr_byte(pat(8'h30, i));
    check("R3 cnt capped", cnt_o, 8);
    check("R3 ovf", ovf_o, 1);
    arm();
    for (int i = 0; i < 8; i++) read_chk("R3 kept bytes", pat(8'h30, i));
    check("R3 no extra", sie_avail_o, 0);
    check("R3 ovf sticky", ovf_o, 1);
    // R10 clear during armed packet
    fw_clr_i = 1; tick(); fw_clr_i = 0;
    check("R10 ovf", ovf_o, 0);
    check("R10 cnt", cnt_o, 0);
    check("R10 armed", armed_o, 0);
    tok_chk("R10 nak after clear", 1);

    // R6 writes while armed
    wr_byte(8'hA1); wr_byte(8'hB2);
    arm();
    wr_byte(8'hC3); wr_byte(8'hD4); wr_byte(8'hE5);
    check("R6 cnt", cnt_o, 2);
    check("R6 no ovf", ovf_o, 0);
    read_chk("R6 data", 8'hA1);
    // R8 retry after partial read
    sie_retry_i = 1; tick(); sie_retry_i = 0;
    check("R8 armed", armed_o, 1);
    read_chk("R8 rewind", 8'hA1);
    read_chk("R8 second", 8'hB2);
    check("R6 end", sie_avail_o, 0);
    sie_retry_i = 1; tick(); sie_retry_i = 0;
    read_chk("R8 full resend", 8'hA1);
    ack();
    check("R7 done after retry", tx_done_o, 1);

    // R10 clear leaves flag
    fw_clr_i = 1; tick(); fw_clr_i = 0;
    check("R10 flag kept", tx_done_o, 1);
    flag_clr();
    check("R9 cleared", tx_done_o, 0);

    // R7 ack while idle
    ack();
    check("R7 idle ack", tx_done_o, 0);

    // R11 zero-length packet
    arm();
    check("R11 armed", armed_o, 1);
    check("R11 cnt", cnt_o, 0);
    check("R11 avail", sie_avail_o, 0);
    tok_chk("R11 no nak", 0);
    // R9 set wins over w1c
    sie_ack_i = 1; fw_flag_clr_i = 1; tick(); sie_ack_i = 0; fw_flag_clr_i = 0;
    check("R11 done", tx_done_o, 1);
    check("R9 set wins", tx_done_o, 1);
    tick();
    check("R9 sticky", tx_done_o, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule